// File: doc/BRIEF.md
# Serial Transmit Controller with Collision Retry

This block turns a stream of packet bytes, offered one at a time by a FIFO-style source, into a serial NRZ bitstream. It runs on the transmit bit clock (nominally 1 MHz), so one bit leaves per clock. Each packet starts with a fixed preamble and a two-bit sync mark. The transmit-enable output is high exactly for the clocks whose bits belong to the packet.

During the data phase the collision input is watched. A collision replaces the rest of the packet with a 32-bit jam of ones. The block then drops transmit enable and waits for an external backoff-done pulse before it restarts the same packet from the preamble. The backoff delay comes from outside; the byte source is expected to rewind itself on that pulse. After a packet ends normally, the block waits a bounded window for the collision-detect heartbeat pulse.

Three sticky status flags report the outcomes: abort after too many collisions, heartbeat missing, and underrun of the byte source. A new accepted start clears all three.

Top module: `sertx_ctrl`

## Requirements
- R1: After reset, tx_en, ser_out, busy and all three status flags are 0.
- R2: A start pulse while busy is 0 begins a packet, and a start pulse while busy is 1 is ignored. The packet begins with PRE_BITS (62) alternating bits starting with 1, followed by SYNC_BITS (2) ones. ser_out is 0 whenever tx_en is 0.
- R3: Data bytes follow the sync bits with no gap, each sent least significant bit first. byte_take pulses for one clock, only with byte_valid, when a byte is taken. The byte taken with byte_last = 1 is the final byte of the packet.
- R4: tx_en is high exactly on the clocks whose ser_out bit belongs to the packet. It rises together with the first preamble bit and falls on the clock after the final bit.
- R5: col_in is ignored while the preamble and sync bits are being sent.
- R6: col_in = 1 during the data phase makes the next 32 transmitted bits ones (jam), replacing the remaining data. tx_en then falls. The block waits for backoff_done and then resends the packet from the preamble.
- R7: A collision on the sixteenth attempt (after MAX_RETRY = 15 retries) sets abort_flag. No further attempt starts and busy returns to 0.
- R8: After a normal end, col_in = 1 within HB_WINDOW (64) clocks, counted from the clock in which the final bit is on the line, ends the packet cleanly. If no such pulse arrives, hb_fail is set.
- R9: byte_valid = 0 when a byte is needed during the data phase ends the packet on that clock: tx_en falls, underrun_flag is set, busy returns to 0, and no heartbeat check is made.
- R10: The status flags stay set until the next accepted start, which clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send one packet |
| byte_valid | input | 1 | Source has a byte ready |
| byte_data | input | 8 | Byte offered by the source |
| byte_last | input | 1 | Offered byte is the packet's final byte |
| byte_take | output | 1 | Byte consumed this clock |
| col_in | input | 1 | Collision / heartbeat indication |
| backoff_done | input | 1 | External backoff delay has expired |
| ser_out | output | 1 | Serial NRZ data |
| tx_en | output | 1 | Transmit enable, frames the packet bits |
| busy | output | 1 | A packet is in progress |
| abort_flag | output | 1 | Retry limit exceeded (sticky) |
| hb_fail | output | 1 | Heartbeat not seen (sticky) |
| underrun_flag | output | 1 | Source ran dry mid-packet (sticky) |

## Verification
The bench builds the block with its default parameters: 62 preamble bits, 2 sync bits, 8-bit bytes, a 32-bit jam, 15 retries and a 64-clock heartbeat window. With these values a full sixteen-attempt abort run fits in a few thousand clocks, so the retry limit is reached with the real counts and not a shrunken stand-in. The same build places collisions inside the preamble, in the middle of a byte and on every attempt. It also covers a heartbeat that never comes and a source that runs dry after its first byte.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the serial transmit controller.
// Assumes: preamble bit order starts with a 1 and alternates.
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRE     = 3'd1,
        ST_DATA    = 3'd2,
        ST_JAM     = 3'd3,
        ST_BACKOFF = 3'd4,
        ST_HB      = 3'd5
    } tx_state_t;

    // Bit sent at position idx of the preamble+sync field.
    function automatic logic pre_bit(input int unsigned idx, input int unsigned n_alt);
        if (idx < n_alt) return (idx % 2) == 0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/sertx_shifter.sv
// Byte serializer: holds the not-yet-sent upper bits of a byte.
// Assumes: the bit 0 of a loaded byte is sent by the caller on load.
module sertx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         head
);
    logic [W-1:0] sh_q;

    // Load the byte shifted by one, or shift right by one each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= din >> 1;
        else if (shift) sh_q <= sh_q >> 1;
    end

    assign head = sh_q[0];
endmodule

// File: rtl/sertx_attempts.sv
// Attempt counter: counts retries of one packet and flags the limit.
// Assumes: clr and inc are never asserted together.
module sertx_attempts #(
    parameter int MAX_RETRY = 15,
    localparam int AW = $clog2(MAX_RETRY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] count,
    output logic          at_limit
);
    // Retry count, cleared per packet, stepped after each jam.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end

    assign at_limit = (count == AW'(MAX_RETRY));
endmodule

// File: rtl/sertx_ctrl.sv
// Serial transmit controller: preamble/sync, LSB-first data, jam and
// automatic retry on collision, heartbeat check after a clean end.
// Assumes: clk is the bit clock; the source rewinds on backoff_done.
module sertx_ctrl #(
    parameter int DATA_W    = 8,
    parameter int PRE_BITS  = 62,
    parameter int SYNC_BITS = 2,
    parameter int JAM_BITS  = 32,
    parameter int MAX_RETRY = 15,
    parameter int HB_WINDOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_last,
    output logic              byte_take,
    input  logic              col_in,
    input  logic              backoff_done,
    output logic              ser_out,
    output logic              tx_en,
    output logic              busy,
    output logic              abort_flag,
    output logic              hb_fail,
    output logic              underrun_flag
);
    import sertx_pkg::*;

    localparam int CNT_W   = $clog2(PRE_BITS + SYNC_BITS + JAM_BITS + HB_WINDOW + 1);
    localparam int BIDX_W  = $clog2(DATA_W);
    localparam int AW      = $clog2(MAX_RETRY + 1);
    localparam int PRE_END = PRE_BITS + SYNC_BITS - 1;
    localparam int JAM_END = JAM_BITS - 2;
    localparam int HB_END  = HB_WINDOW - 1;

    tx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIDX_W-1:0] bidx_q;
    logic              last_q;
    logic              ser_q, txen_q;
    logic              abort_q, hbf_q, und_q;
    logic              head;
    logic              start_ok, atm_inc, at_limit, shift_en;
    logic [AW-1:0]     atm_cnt;

    assign busy      = (state_q != ST_IDLE) || txen_q;
    assign start_ok  = start && !busy;
    assign byte_take = (state_q == ST_DATA) && !col_in && (bidx_q == '0) && byte_valid;
    assign shift_en  = (state_q == ST_DATA) && !col_in && (bidx_q != '0);
    assign atm_inc   = (state_q == ST_JAM) && (cnt_q == CNT_W'(JAM_END)) && !at_limit;

    sertx_shifter #(.W(DATA_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .load(byte_take), .shift(shift_en),
        .din(byte_data), .head(head)
    );

    sertx_attempts #(.MAX_RETRY(MAX_RETRY)) atm_i (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(atm_inc),
        .count(atm_cnt), .at_limit(at_limit)
    );

    // Sequencer: state, counters, line outputs and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bidx_q  <= '0;
            last_q  <= 1'b0;
            ser_q   <= 1'b0;
            txen_q  <= 1'b0;
            abort_q <= 1'b0;
            hbf_q   <= 1'b0;
            und_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    ser_q  <= 1'b0;
                    txen_q <= 1'b0;
                    if (start_ok) begin
                        abort_q <= 1'b0;
                        hbf_q   <= 1'b0;
                        und_q   <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    ser_q  <= pre_bit(32'(cnt_q), PRE_BITS);
                    txen_q <= 1'b1;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(PRE_END)) begin
                        bidx_q  <= '0;
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    txen_q <= 1'b1;
                    if (col_in) begin
                        ser_q   <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= ST_JAM;
                    end else if (bidx_q == '0) begin
                        if (byte_valid) begin
                            ser_q  <= byte_data[0];
                            last_q <= byte_last;
                            bidx_q <= BIDX_W'(1);
                        end else begin
                            ser_q   <= 1'b0;
                            txen_q  <= 1'b0;
                            und_q   <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        ser_q <= head;
                        if (bidx_q == BIDX_W'(DATA_W - 1)) begin
                            bidx_q <= '0;
                            if (last_q) begin
                                cnt_q   <= '0;
                                state_q <= ST_HB;
                            end
                        end else begin
                            bidx_q <= bidx_q + 1'b1;
                        end
                    end
                end
                ST_JAM: begin
                    ser_q  <= 1'b1;
                    txen_q <= 1'b1;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(JAM_END)) begin
                        if (at_limit) begin
                            abort_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_BACKOFF;
                        end
                    end
                end
                ST_BACKOFF: begin
                    ser_q  <= 1'b0;
                    txen_q <= 1'b0;
                    if (backoff_done) begin
                        cnt_q   <= '0;
                        state_q <= ST_PRE;
                    end
                end
                ST_HB: begin
                    ser_q  <= 1'b0;
                    txen_q <= 1'b0;
                    cnt_q  <= cnt_q + 1'b1;
                    if (col_in) begin
                        state_q <= ST_IDLE;
                    end else if (cnt_q == CNT_W'(HB_END)) begin
                        hbf_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ser_out       = ser_q;
    assign tx_en         = txen_q;
    assign abort_flag    = abort_q;
    assign hb_fail       = hbf_q;
    assign underrun_flag = und_q;
endmodule

// File: rtl/sertx_ctrl_chk.sv
// Property checker for sertx_ctrl, attached with bind below.
// Assumes: state and attempt count are brought out by the bind.
module sertx_ctrl_chk #(
    parameter int MAX_RETRY = 15,
    localparam int AW = $clog2(MAX_RETRY + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 byte_valid,
    input logic                 byte_take,
    input logic                 col_in,
    input logic                 ser_out,
    input logic                 tx_en,
    input logic                 busy,
    input logic                 abort_flag,
    input logic                 hb_fail,
    input logic                 underrun_flag,
    input sertx_pkg::tx_state_t state,
    input logic [AW-1:0]        attempts
);
    import sertx_pkg::*;

    p_idle_line_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !ser_out);

    p_take_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> byte_valid);

    p_pre_col_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE && col_in) |=> state != ST_JAM);

    p_jam_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JAM) |=> (ser_out && tx_en));

    p_abort_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> attempts == AW'(MAX_RETRY));

    p_abort_goes_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |=> (!tx_en && state == ST_IDLE));

    p_flags_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!abort_flag && !hb_fail && !underrun_flag));

    p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && !(start && !busy)) |=> abort_flag);
endmodule

bind sertx_ctrl sertx_ctrl_chk #(.MAX_RETRY(MAX_RETRY)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .byte_take(byte_take), .col_in(col_in), .ser_out(ser_out), .tx_en(tx_en),
    .busy(busy), .abort_flag(abort_flag), .hb_fail(hb_fail),
    .underrun_flag(underrun_flag), .state(state_q), .attempts(atm_cnt)
);

// File: tb/sertx_ctrl_tb_top.sv
// Directed bench for sertx_ctrl: one task per scenario.
module sertx_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPRE       = 64;
    localparam int CAP        = 256;

    logic       clk = 0, rst_n = 0, start = 0;
    logic       byte_take, ser_out, tx_en, busy, abort_flag, hb_fail, underrun_flag;
    logic       byte_valid, byte_last, col_in, backoff_done;
    logic [7:0] byte_data;

    logic [7:0] pkt [16];
    int  src_len = 0, src_idx = 0;
    bit  src_on = 0, last_mark = 1, rw_task = 0, rw_mon = 0;

    bit  cap [CAP];
    bit  cap1 [CAP];
    int  cap_len = 0, cap1_len = 0, attempts = 0;
    bit  prev_en = 0, injected = 0, col_hb = 0, col_inj = 0, bk_pulse = 0;
    int  hb_delay = 3, hb_cnt = 0, bk_cnt = 0, inj_left = 0, inj_at = 0;
    bit  hb_on = 1;
    int  n_checks = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_last(byte_last), .byte_take(byte_take),
        .col_in(col_in), .backoff_done(backoff_done), .ser_out(ser_out),
        .tx_en(tx_en), .busy(busy), .abort_flag(abort_flag), .hb_fail(hb_fail),
        .underrun_flag(underrun_flag)
    );

    assign byte_valid   = src_on && (src_idx < src_len);
    assign byte_data    = pkt[src_idx[3:0]];
    assign byte_last    = last_mark && (src_idx == src_len - 1);
    assign col_in       = col_hb | col_inj;
    assign backoff_done = bk_pulse;

    // Byte source model: advances on take, rewinds on request.
    always @(posedge clk) begin
        if (!rst_n || rw_task || rw_mon) src_idx <= 0;
        else if (byte_take)               src_idx <= src_idx + 1;
    end

    // Line monitor plus heartbeat, collision and backoff responders.
    always @(negedge clk) begin
        col_hb = 0; col_inj = 0; bk_pulse = 0; rw_mon = 0;
        if (tx_en && !prev_en) begin
            attempts++; cap_len = 0; injected = 0;
        end
        if (tx_en && cap_len < CAP) begin
            cap[cap_len] = ser_out; cap_len++;
        end
        if (!tx_en && prev_en) begin
            if (attempts == 1) begin
                for (int i = 0; i < CAP; i++) cap1[i] = cap[i];
                cap1_len = cap_len;
            end
            if (injected) bk_cnt = 5;
            else if (hb_on) hb_cnt = hb_delay;
        end else begin
            if (hb_cnt > 0) begin hb_cnt--; if (hb_cnt == 0) col_hb = 1; end
            if (bk_cnt > 0) begin
                bk_cnt--;
                if (bk_cnt == 0) begin bk_pulse = 1; rw_mon = 1; end
            end
        end
        if (inj_left > 0 && tx_en && !injected && cap_len == inj_at) begin
            col_inj = 1; injected = 1; inj_left--;
        end
        prev_en = tx_en;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 20000);
    endtask

    task automatic load_pkt(input int n, input bit lastm);
        for (int i = 0; i < n; i++) pkt[i] = 8'(8'h5B * (i + 3) ^ (i << 4));
        src_len = n; last_mark = lastm; src_on = 1;
        @(negedge clk) rw_task = 1;
        @(negedge clk) rw_task = 0;
        attempts = 0;
    endtask

    function automatic bit exp_bit(input int k);
        if (k < 62) return (k % 2) == 0;
        if (k < NPRE) return 1'b1;
        return pkt[(k - NPRE) / 8][(k - NPRE) % 8];
    endfunction

    // Compare preamble, sync and first nb data bits of a capture.
    task automatic check_stream(input bit use1, input int nbits, input string tag);
        int bad = 0;
        for (int k = 0; k < nbits; k++)
            if ((use1 ? cap1[k] : cap[k]) != exp_bit(k)) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        check(tx_en == 0 && ser_out == 0, "R1 line idle", int'(tx_en), 0);
        check(busy == 0, "R1 busy", int'(busy), 0);
        check({abort_flag, hb_fail, underrun_flag} == 3'b000, "R1 flags",
              int'({abort_flag, hb_fail, underrun_flag}), 0);
    endtask

    task automatic t_basic();
        load_pkt(3, 1);
        hb_on = 1; hb_delay = 3;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();                      // ignored while busy (R2)
        wait_idle();
        repeat (10) @(negedge clk);
        check(attempts == 1, "R2 second start ignored", attempts, 1);
        check_stream(0, NPRE, "R2 preamble and sync bits");
        check_stream(0, NPRE + 24, "R3 data LSB first");
        check(src_idx == 3, "R3 bytes taken", src_idx, 3);
        check(cap_len == NPRE + 24, "R4 tx_en bit count", cap_len, NPRE + 24);
        check(hb_fail == 0, "R8 heartbeat seen", int'(hb_fail), 0);
    endtask

    task automatic t_pre_col();
        load_pkt(2, 1);
        inj_left = 1; inj_at = 30;
        pulse_start();
        wait_idle();
        repeat (10) @(negedge clk);
        inj_left = 0;
        check(attempts == 1, "R5 no retry from preamble collision", attempts, 1);
        check(cap_len == NPRE + 16, "R5 length", cap_len, NPRE + 16);
        check_stream(0, NPRE + 16, "R5 stream intact");
    endtask

    task automatic t_collision();
        int ones = 0;
        load_pkt(3, 1);
        inj_left = 1; inj_at = NPRE + 10;
        pulse_start();
        wait_idle();
        repeat (10) @(negedge clk);
        check(attempts == 2, "R6 one retry", attempts, 2);
        check(cap1_len == NPRE + 10 + 32, "R6 jammed length", cap1_len, NPRE + 42);
        check_stream(1, NPRE + 10, "R6 bits before jam");
        for (int k = NPRE + 10; k < NPRE + 42; k++) ones += int'(cap1[k]);
        check(ones == 32, "R6 jam ones", ones, 32);
        check(cap_len == NPRE + 24, "R6 retry length", cap_len, NPRE + 24);
        check_stream(0, NPRE + 24, "R6 retry stream");
        check(abort_flag == 0, "R6 no abort", int'(abort_flag), 0);
    endtask

    task automatic t_abort();
        load_pkt(3, 1);
        inj_left = 16; inj_at = NPRE + 5;
        pulse_start();
        wait_idle();
        repeat (30) @(negedge clk);
        check(attempts == 16, "R7 sixteen attempts", attempts, 16);
        check(abort_flag == 1, "R7 abort set", int'(abort_flag), 1);
        check(busy == 0 && tx_en == 0, "R7 idle after abort", int'(busy), 0);
        check(abort_flag == 1, "R10 abort sticky", int'(abort_flag), 1);
        inj_left = 0;
    endtask

    task automatic t_no_hb();
        load_pkt(1, 1);
        hb_on = 0;
        pulse_start();
        repeat (3) @(negedge clk);
        check(abort_flag == 0, "R10 start clears abort", int'(abort_flag), 0);
        wait_idle();
        repeat (5) @(negedge clk);
        check(hb_fail == 1, "R8 heartbeat missing", int'(hb_fail), 1);
        hb_on = 1;
    endtask

    task automatic t_underrun();
        load_pkt(1, 0);
        pulse_start();
        repeat (3) @(negedge clk);
        check(hb_fail == 0, "R10 start clears hb_fail", int'(hb_fail), 0);
        wait_idle();
        repeat (5) @(negedge clk);
        check(cap_len == NPRE + 8, "R9 stops after last full byte", cap_len, NPRE + 8);
        check(underrun_flag == 1, "R9 underrun set", int'(underrun_flag), 1);
        check(hb_fail == 0 && tx_en == 0, "R9 no heartbeat check", int'(hb_fail), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_basic();
        t_pre_col();
        t_collision();
        t_abort();
        t_no_hb();
        t_underrun();
        summary();
        $finish;
    end
endmodule